// File: doc/BRIEF.md
# Composite Sync-ID Word Inserter

Composite digital video carries digitized analog sync instead of embedded timing codes, so a serial receiver has nothing to align its word boundaries to. This block sits ahead of the serializer and fixes that. At a fixed sample position on every line, just after the leading edge of analog sync, it overwrites five samples. The first is a word of all ones. The next three are words of all zeros. The last is an identification word that carries a restricted line count and the colour-framing field count.

The sample position depends on the selected television standard (PAL or NTSC). The position count restarts on a line-start strobe. A strip mode serves the receiving side: it replaces the same five samples with the blanking code, so the marker does not reach the parallel output. Every other sample passes through unchanged, one enabled clock later. A clock enable qualifies each incoming sample.

Top module: `cvid_syncid_ins`

## Requirements
- R1: While reset is asserted, and until the first enabled sample after reset, `smp_out` is 0x000 and `out_en` is 0.
- R2: Each sample accepted with `smp_en` high appears on `smp_out` with `out_en` high on the following clock. Samples outside the window appear unchanged, including samples accepted before the first line start.
- R3: With `pal_mode` high, the window covers positions 967 to 971. Position 0 is the sample accepted together with `line_start`, and each later enabled sample adds one.
- R4: With `pal_mode` low (NTSC), the window covers positions 790 to 794.
- R5: Inside the window, insert mode emits 0x3FF at the first position, 0x000 at the second, third and fourth positions, and the identification word at the fifth.
- R6: Identification word layout: bits 9:8 are binary 10, bits 7:3 hold the line count, and bits 2:0 hold the field count. The word therefore never equals 0x3FF or 0x000.
- R7: The line count equals `line_num` for lines 0 to 30 and is 31 for line 31 and every later line.
- R8: In PAL the field count is `field_num` (0 to 7). In NTSC bit 2 of the field count is forced to 0, so it ranges 0 to 3.
- R9: With `strip_mode` high, all five window positions emit the blanking code 0x040 instead of the inserted words.
- R10: A `line_start` restarts the count at position 0 even in the middle of a window. That sample and the rest of the interrupted window pass through unchanged.
- R11: A cycle with `smp_en` low accepts no sample and does not advance the position. On the next clock, `out_en` is 0 and `smp_out` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_en | input | 1 | Clock enable: a sample is present on `smp_in` |
| smp_in | input | 10 | Incoming composite sample |
| line_start | input | 1 | Marks the enabled sample as position 0 of a line |
| pal_mode | input | 1 | 1 selects PAL positions and field range, 0 selects NTSC |
| strip_mode | input | 1 | 1 replaces window words with blanking, 0 inserts the sequence |
| line_num | input | 10 | Current line number |
| field_num | input | 3 | Colour-framing field number |
| smp_out | output | 10 | Outgoing sample stream |
| out_en | output | 1 | `smp_out` carries a new sample this cycle |

## Verification
Two functions can land on the same enabled sample: a line restart and a word in the middle of the window. The bench provokes this by raising `line_start` at NTSC position 792, while the window is still replacing zeros words. It expects that sample and the next ones back as untouched input data, because the restart must win and cancel the rest of the window. A second collision is an idle gap inside the window. There the bench expects the held output and the remaining words to stay in their position order.

// File: rtl/cvid_pkg.sv
package cvid_pkg;
  localparam int SMP_W = 10;
  typedef logic [SMP_W-1:0] smp_t;

  localparam smp_t CODE_ONES  = '1;
  localparam smp_t CODE_ZERO  = '0;
  localparam smp_t CODE_BLANK = smp_t'(10'h040);
  localparam logic [1:0] ID_TAG = 2'b10;

  typedef enum logic [2:0] {
    WK_PASS  = 3'd0,
    WK_ONES  = 3'd1,
    WK_ZERO  = 3'd2,
    WK_ID    = 3'd3,
    WK_BLANK = 3'd4
  } wkind_e;
endpackage

// File: rtl/cvid_pos_ctr.sv
module cvid_pos_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  output logic [CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // position of the sample on the input this cycle; saturates until a restart
  always_comb begin
    if (restart)              pos = '0;
    else if (cnt_q == CNT_MAX) pos = CNT_MAX;
    else                      pos = cnt_q + 1'b1;
    cnt_d = en ? pos : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart) |=> (cnt_q == '0)); // R10
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/cvid_win_dec.sv
module cvid_win_dec
  import cvid_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int PAL_POS  = 967,
  parameter int NTSC_POS = 790,
  parameter int WIN_LEN  = 5
) (
  input  logic [CNT_W-1:0] pos,
  input  logic             pal,
  input  logic             strip,
  output wkind_e           kind
);
  localparam int IDX_W = $clog2(WIN_LEN);
  localparam logic [CNT_W-1:0] PAL_S  = CNT_W'(PAL_POS);
  localparam logic [CNT_W-1:0] NTSC_S = CNT_W'(NTSC_POS);
  localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(WIN_LEN);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] start, off;
  logic [IDX_W-1:0] idx;
  logic             in_win;

  always_comb begin
    start  = pal ? PAL_S : NTSC_S;
    off    = pos - start;
    in_win = (pos >= start) && (off < LEN_C);
    idx    = off[IDX_W-1:0];
    if (!in_win)              kind = WK_PASS;
    else if (strip)           kind = WK_BLANK;
    else if (idx == '0)       kind = WK_ONES;
    else if (idx == LAST_I)   kind = WK_ID;
    else                      kind = WK_ZERO;
  end
endmodule

// File: rtl/cvid_id_fmt.sv
module cvid_id_fmt
  import cvid_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int SAT    = 31
) (
  input  logic [LINE_W-1:0] line,
  input  logic [2:0]        field,
  input  logic              pal,
  output smp_t              id
);
  localparam int LC_W = SMP_W - 2 - 3;

  logic [LC_W-1:0] lcnt;
  logic [2:0]      fcnt;

  always_comb begin
    lcnt = (line >= LINE_W'(SAT)) ? LC_W'(SAT) : line[LC_W-1:0];
    fcnt = pal ? field : {1'b0, field[1:0]};
    id   = {ID_TAG, lcnt, fcnt};
  end
endmodule

// File: rtl/cvid_out_stage.sv
module cvid_out_stage
  import cvid_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  smp_t   din,
  input  smp_t   id,
  input  wkind_e kind,
  output smp_t   dout,
  output logic   dval
);
  smp_t word_d, dout_d;

  always_comb begin
    case (kind)
      WK_ONES:  word_d = CODE_ONES;
      WK_ZERO:  word_d = CODE_ZERO;
      WK_ID:    word_d = id;
      WK_BLANK: word_d = CODE_BLANK;
      default:  word_d = din;
    endcase
    dout_d = en ? word_d : dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dval <= 1'b0;
    end else begin
      dout <= dout_d;
      dval <= en;
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == WK_PASS) |=> (dout == $past(din))); // R2
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> dval); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(dout) && !dval)); // R11
  AST_ID_NOT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == WK_ID) |=> (dout != CODE_ONES && dout != CODE_ZERO)); // R6
  AST_STRIP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && kind == WK_BLANK) |=> (dout == CODE_BLANK)); // R9
endmodule

// File: rtl/cvid_syncid_ins.sv
module cvid_syncid_ins
  import cvid_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int LINE_W   = 10,
  parameter int PAL_POS  = 967,
  parameter int NTSC_POS = 790,
  parameter int WIN_LEN  = 5,
  parameter int LINE_SAT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [SMP_W-1:0]  smp_in,
  input  logic              line_start,
  input  logic              pal_mode,
  input  logic              strip_mode,
  input  logic [LINE_W-1:0] line_num,
  input  logic [2:0]        field_num,
  output logic [SMP_W-1:0]  smp_out,
  output logic              out_en
);
  logic rst_meta, rst_sync;
  logic [CNT_W-1:0] pos;
  wkind_e kind;
  smp_t   id_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cvid_pos_ctr #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_sync), .en(smp_en), .restart(line_start), .pos(pos)
  );

  cvid_win_dec #(
    .CNT_W(CNT_W), .PAL_POS(PAL_POS), .NTSC_POS(NTSC_POS), .WIN_LEN(WIN_LEN)
  ) u_dec (
    .pos(pos), .pal(pal_mode), .strip(strip_mode), .kind(kind)
  );

  cvid_id_fmt #(.LINE_W(LINE_W), .SAT(LINE_SAT)) u_id (
    .line(line_num), .field(field_num), .pal(pal_mode), .id(id_word)
  );

  cvid_out_stage u_out (
    .clk(clk), .rst_n(rst_sync), .en(smp_en), .din(smp_in), .id(id_word),
    .kind(kind), .dout(smp_out), .dval(out_en)
  );
endmodule

// File: tb/cvid_syncid_ins_tb_top.sv
`timescale 1ns/1ps
module cvid_syncid_ins_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic [9:0] smp_in = '0;
  logic       line_start = 1'b0;
  logic       pal_mode = 1'b1;
  logic       strip_mode = 1'b0;
  logic [9:0] line_num = '0;
  logic [2:0] field_num = '0;
  logic [9:0] smp_out;
  logic       out_en;

  always #4 clk = ~clk;

  cvid_syncid_ins dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
    .line_start(line_start), .pal_mode(pal_mode), .strip_mode(strip_mode),
    .line_num(line_num), .field_num(field_num), .smp_out(smp_out), .out_en(out_en)
  );

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  int         tag_q[$];
  int         bpos = 2047;
  logic       en_d = 1'b0;
  logic [9:0] last_out = '0;

  function automatic string tname(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input int t, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tname(t), act, exp, $time);
    end
  endtask

  function automatic logic [9:0] idw(input int ln, input logic [2:0] f, input bit pal);
    logic [4:0] l5;
    l5 = (ln >= 31) ? 5'd31 : 5'(ln);
    return {2'b10, l5, pal ? f : {1'b0, f[1:0]}};
  endfunction

  // driver: one enabled sample, expected result pushed to the scoreboard
  task automatic send(input logic [9:0] d, input bit ls,
                      input int wtag, input int itag, input int ptag);
    int st, k;
    logic [9:0] e;
    int t;
    @(negedge clk);
    smp_in = d; line_start = ls; smp_en = 1'b1;
    bpos = ls ? 0 : ((bpos == 2047) ? 2047 : bpos + 1);
    st = pal_mode ? 967 : 790;
    e = d; t = ptag;
    if (bpos >= st && bpos < st + 5) begin
      k = bpos - st;
      if (strip_mode)  begin e = 10'h040; t = 9; end
      else if (k == 0) begin e = 10'h3FF; t = wtag; end
      else if (k == 4) begin e = idw(int'(line_num), field_num, pal_mode); t = itag; end
      else             begin e = 10'h000; t = wtag; end
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    smp_en = 1'b0; line_start = 1'b0;
  endtask

  task automatic set_mode(input bit pal, input bit strip, input int ln, input int f);
    @(negedge clk);
    smp_en = 1'b0; line_start = 1'b0;
    pal_mode = pal; strip_mode = strip; line_num = 10'(ln); field_num = 3'(f);
  endtask

  // a line of n samples; optional idle gaps before positions ga and gb
  task automatic send_line(input int n, input int seed, input int wtag, input int itag,
                           input int ga, input int gb);
    for (int i = 0; i < n; i++) begin
      if (i == ga || i == gb) idle();
      send(10'((i * 37 + seed) % 1024), (i == 0), wtag, itag, 2);
    end
  endtask

  always @(posedge clk) en_d <= smp_en;

  // monitor
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (out_en !== en_d) begin
        errors++;
        $display("FAIL R11 out_en actual=%b expected=%b at %0t", out_en, en_d, $time);
      end
      if (out_en === 1'b1) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R2 actual=%h expected=none (unexpected output)", smp_out);
        end else begin
          check(tag_q.pop_front(), smp_out, exp_q.pop_front());
        end
      end else begin
        check(11, smp_out, last_out);
      end
      last_out = smp_out;
    end
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(1, smp_out, 10'h000);
    check(1, {9'd0, out_en}, 10'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, smp_out, 10'h000);
    started = 1;

    // R2: stream before any line start passes, including an all-ones sample
    set_mode(1, 0, 5, 6);
    for (int i = 0; i < 20; i++) send((i == 7) ? 10'h3FF : 10'(i * 51), 0, 2, 2, 2);

    // R3 R5 R6 R11: PAL line 5 field 6, idle gaps inside the window
    send_line(1000, 3, 5, 6, 968, 971);
    // R3 R7: PAL line 40 saturates, field 7
    set_mode(1, 0, 40, 7);
    send_line(990, 11, 3, 7, -1, -1);
    // R4 R7 R8: NTSC line 31, field 7 masked to 3
    set_mode(0, 0, 31, 7);
    send_line(820, 5, 4, 8, -1, -1);
    // R4 R7: NTSC line 30 just below saturation, field 2
    set_mode(0, 0, 30, 2);
    send_line(820, 9, 4, 7, 792, -1);
    // R9: PAL strip mode
    set_mode(1, 1, 12, 3);
    send_line(990, 17, 9, 9, -1, -1);
    // R10: NTSC line restarted at position 792, inside the window
    set_mode(0, 0, 8, 1);
    send_line(792, 21, 4, 6, -1, -1);
    for (int i = 0; i < 12; i++) send(10'(i * 83 + 1), (i == 0), 4, 6, 10);
    // R10: the restarted count still reaches the window afterwards
    for (int i = 12; i < 800; i++) send(10'(i * 13), 0, 4, 6, 2);

    repeat (4) idle();
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 actual=%0d expected=0 pending outputs", exp_q.size());
    end
    started = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule